// File: doc/BRIEF.md
# Dual-Port Fast GPIO Register Block

This block holds the software-driven state of a bank of general-purpose pins and sits on the single-cycle local port of two processors. Both processors see the same pin registers. The block keeps an output-value register and an output-enable register, and it drives the pin output and output-enable vectors from them. It also samples the input pins through a two-flop synchronizer and returns them as a read-only register. Pin multiplexing, pad settings and pin interrupts live elsewhere.

The local port has no generic address-offset alias scheme. Each of the two registers therefore has three alias addresses of its own, which set, clear or toggle the bits given in the write mask. Software can then change single bits atomically, with no read-modify-write, even while the other processor touches the same register. A read returns its data in the same cycle as the address. A write takes effect on the pins at the next clock edge. When both ports write in the same cycle, the operations are combined in a fixed order.

Top module: `fastio_pins`

## Requirements
- R1: After reset, and while reset is asserted, pin_out and pin_oe are all zeros.
- R2: A write to OUT (address 1) replaces the whole output register with wdata[29:0]. Write bits 31:30 are ignored, and read data bits 31:30 are always zero.
- R3: A write to OUT_SET (address 2) ORs the mask into the output register.
- R4: A write to OUT_CLR (address 3) clears the masked bits of the output register.
- R5: A write to OUT_TGL (address 4) XORs the mask into the output register.
- R6: The output-enable register is the same kind of register: plain write at address 5, set at 6, clear at 7, toggle at 8. It drives pin_oe and is independent of the output register.
- R7: A read with en=1 and we=0 returns its data combinationally in the same cycle. Addresses 1 to 4 return the output register, and addresses 5 to 8 return the output-enable register.
- R8: Address 0 (IN) returns pin_in delayed by two clock edges.
- R9: When both ports write the same register in one cycle, the operations are applied as follows. Plain writes come first, with port 1 overriding port 0. Then clears are applied, then sets, then toggles, port 0 before port 1 within each step.
- R10: Writes to address 0 or to addresses 9 to 15 change nothing. Reads of addresses 9 to 15, and any read with en=0, return zero.
- R11: A write becomes visible on pin_out and pin_oe at the first clock edge after it, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p0_en | input | 1 | Port 0 access strobe |
| p0_we | input | 1 | Port 0 write (1) or read (0) |
| p0_addr | input | 4 | Port 0 register address |
| p0_wdata | input | 32 | Port 0 write data or mask |
| p0_rdata | output | 32 | Port 0 read data, same cycle |
| p1_en | input | 1 | Port 1 access strobe |
| p1_we | input | 1 | Port 1 write (1) or read (0) |
| p1_addr | input | 4 | Port 1 register address |
| p1_wdata | input | 32 | Port 1 write data or mask |
| p1_rdata | output | 32 | Port 1 read data, same cycle |
| pin_in | input | 30 | Raw pin input levels |
| pin_out | output | 30 | Pin output values |
| pin_oe | output | 30 | Pin output enables |

## Verification
The bench focuses on collisions between the two ports. It pairs a set with a clear on the same bit, a plain write with a toggle, a clear with a toggle, and two plain writes. A design that applied the operations in the wrong order, or that let one port's operation override the other's, would leave the wrong bit value on the pins. It also checks that the upper write bits never reach the pins and that unmapped or read-only addresses leave the registers untouched. A design that decoded addresses loosely would corrupt the output or enable register in those cases. It checks the input path latency, which catches a missing or extra synchronizer stage, and it checks that writes do not reach the pins before the clock edge.

// File: rtl/fastio_pins.sv
module fastio_pins #(
  parameter int W  = 30,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p0_en,
  input  logic          p0_we,
  input  logic [3:0]    p0_addr,
  input  logic [DW-1:0] p0_wdata,
  output logic [DW-1:0] p0_rdata,
  input  logic          p1_en,
  input  logic          p1_we,
  input  logic [3:0]    p1_addr,
  input  logic [DW-1:0] p1_wdata,
  output logic [DW-1:0] p1_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe
);
  localparam logic [3:0] A_IN  = 4'd0;
  localparam logic [3:0] A_OUT = 4'd1;
  localparam logic [3:0] A_OE  = 4'd5;

  logic [W-1:0] out_q, oe_q, sync1_q, sync2_q;
  logic         w0, w1;
  logic         unused_hi;

  assign w0 = p0_en && p0_we;
  assign w1 = p1_en && p1_we;
  assign unused_hi = ^{p0_wdata[DW-1:W], p1_wdata[DW-1:W]};

  function automatic logic [W-1:0] next_val(
    input logic [W-1:0] cur, input logic [3:0] base,
    input logic wa, input logic [3:0] aa, input logic [W-1:0] da,
    input logic wb, input logic [3:0] ab, input logic [W-1:0] db);
    logic [W-1:0] v;
    v = cur;
    if (wa && aa == base)         v = da;
    if (wb && ab == base)         v = db;
    if (wa && aa == base + 4'd2)  v = v & ~da;
    if (wb && ab == base + 4'd2)  v = v & ~db;
    if (wa && aa == base + 4'd1)  v = v | da;
    if (wb && ab == base + 4'd1)  v = v | db;
    if (wa && aa == base + 4'd3)  v = v ^ da;
    if (wb && ab == base + 4'd3)  v = v ^ db;
    return v;
  endfunction

  function automatic logic [DW-1:0] read_val(input logic en, input logic [3:0] a,
    input logic [W-1:0] o, input logic [W-1:0] e, input logic [W-1:0] s);
    logic [W-1:0] v;
    if (!en)                         v = '0;
    else if (a == A_IN)              v = s;
    else if (a >= A_OUT && a < A_OE) v = o;
    else if (a >= A_OE && a <= A_OE + 4'd3) v = e;
    else                             v = '0;
    return {{(DW-W){1'b0}}, v};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      oe_q    <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      out_q   <= next_val(out_q, A_OUT, w0, p0_addr, p0_wdata[W-1:0],
                          w1, p1_addr, p1_wdata[W-1:0]);
      oe_q    <= next_val(oe_q, A_OE, w0, p0_addr, p0_wdata[W-1:0],
                          w1, p1_addr, p1_wdata[W-1:0]);
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  assign p0_rdata = read_val(p0_en && !p0_we, p0_addr, out_q, oe_q, sync2_q);
  assign p1_rdata = read_val(p1_en && !p1_we, p1_addr, out_q, oe_q, sync2_q);
  assign pin_out  = out_q;
  assign pin_oe   = oe_q;
endmodule

// File: rtl/fastio_pins_chk.sv
module fastio_pins_chk #(
  parameter int W  = 30,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          p0_en,
  input logic          p0_we,
  input logic [3:0]    p0_addr,
  input logic [DW-1:0] p0_wdata,
  input logic [DW-1:0] p0_rdata,
  input logic          p1_en,
  input logic          p1_we,
  input logic [3:0]    p1_addr,
  input logic [DW-1:0] p1_wdata,
  input logic [DW-1:0] p1_rdata,
  input logic [W-1:0]  pin_out,
  input logic [W-1:0]  pin_oe
);
  logic w0, w1, w0_out, w1_out, w0_oe, w1_oe;
  assign w0 = p0_en && p0_we;
  assign w1 = p1_en && p1_we;
  assign w0_out = w0 && p0_addr >= 4'd1 && p0_addr <= 4'd4;
  assign w1_out = w1 && p1_addr >= 4'd1 && p1_addr <= 4'd4;
  assign w0_oe  = w0 && p0_addr >= 4'd5 && p0_addr <= 4'd8;
  assign w1_oe  = w1 && p1_addr >= 4'd5 && p1_addr <= 4'd8;

  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(w0_out || w1_out) |=> $stable(pin_out));
  p_oe_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(w0_oe || w1_oe) |=> $stable(pin_oe));
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (w0 && p0_addr == 4'd2 && !w1_out) |=>
      ((pin_out & $past(p0_wdata[W-1:0])) == $past(p0_wdata[W-1:0])));
  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (w0 && p0_addr == 4'd3 && !w1_out) |=> ((pin_out & $past(p0_wdata[W-1:0])) == '0));
  p_tgl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (w0 && p0_addr == 4'd4 && !w1_out) |=> (pin_out == $past(pin_out ^ p0_wdata[W-1:0])));
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_rdata[DW-1:W] == '0) && (p1_rdata[DW-1:W] == '0));
endmodule

bind fastio_pins fastio_pins_chk #(.W(W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .p0_en(p0_en), .p0_we(p0_we), .p0_addr(p0_addr), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
  .p1_en(p1_en), .p1_we(p1_we), .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe));

// File: tb/tb_fastio_pins.sv
module tb_fastio_pins;
  logic clk = 0, rst_n = 0;
  logic p0_en = 0, p0_we = 0, p1_en = 0, p1_we = 0;
  logic [3:0] p0_addr = 0, p1_addr = 0;
  logic [31:0] p0_wdata = 0, p1_wdata = 0, p0_rdata, p1_rdata;
  logic [29:0] pin_in = 0, pin_out, pin_oe;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  fastio_pins dut (.*);

  // {p0 write, p0 addr, p0 data, p1 write, p1 addr, p1 data, expected out, expected oe}
  localparam int NV = 13;
  localparam logic [133:0] VEC [NV] = '{
    {1'b1,4'd1,32'hFFFF0000, 1'b0,4'd0,32'h0,        30'h3FFF0000, 30'h0},        // R2
    {1'b1,4'd2,32'h000000FF, 1'b0,4'd0,32'h0,        30'h3FFF00FF, 30'h0},        // R3
    {1'b0,4'd0,32'h0,        1'b1,4'd3,32'h0F00000F, 30'h30FF00F0, 30'h0},        // R4
    {1'b1,4'd4,32'h0000FFFF, 1'b0,4'd0,32'h0,        30'h30FFFF0F, 30'h0},        // R5
    {1'b0,4'd0,32'h0,        1'b1,4'd5,32'h12345678, 30'h30FFFF0F, 30'h12345678}, // R6
    {1'b1,4'd6,32'h00000001, 1'b1,4'd7,32'h00000008, 30'h30FFFF0F, 30'h12345671}, // R6
    {1'b1,4'd8,32'hFFFFFFFF, 1'b0,4'd0,32'h0,        30'h30FFFF0F, 30'h2DCBA98E}, // R6
    {1'b1,4'd2,32'h00000010, 1'b1,4'd3,32'h00000010, 30'h30FFFF1F, 30'h2DCBA98E}, // R9 clear then set
    {1'b1,4'd1,32'h00000AAA, 1'b1,4'd4,32'h0000000F, 30'h00000AA5, 30'h2DCBA98E}, // R9 write then toggle
    {1'b1,4'd1,32'h00000001, 1'b1,4'd1,32'h00000002, 30'h00000002, 30'h2DCBA98E}, // R9 port 1 wins
    {1'b1,4'd3,32'h00000002, 1'b1,4'd4,32'h00000002, 30'h00000002, 30'h2DCBA98E}, // R9 clear then toggle
    {1'b1,4'd15,32'hFFFFFFFF,1'b1,4'd0,32'hFFFFFFFF, 30'h00000002, 30'h2DCBA98E}, // R10
    {1'b1,4'd6,32'hFFFFFFFF, 1'b1,4'd7,32'hFFFFFFFF, 30'h00000002, 30'h3FFFFFFF}  // R9
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    p0_en = 0; p0_we = 0; p0_addr = 0; p0_wdata = 0;
    p1_en = 0; p1_we = 0; p1_addr = 0; p1_wdata = 0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 out in reset", {2'b0, pin_out}, 0);
    check("R1 oe in reset", {2'b0, pin_oe}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 out after reset", {2'b0, pin_out}, 0);

    for (int i = 0; i < NV; i++) begin
      p0_en = VEC[i][133]; p0_we = VEC[i][133]; p0_addr = VEC[i][132:129]; p0_wdata = VEC[i][128:97];
      p1_en = VEC[i][96];  p1_we = VEC[i][96];  p1_addr = VEC[i][95:92];   p1_wdata = VEC[i][91:60];
      @(negedge clk);
      idle();
      check($sformatf("R2 R3 R4 R5 R9 R10 out vec %0d", i), {2'b0, pin_out}, {2'b0, VEC[i][59:30]});
      check($sformatf("R6 R9 R10 oe vec %0d", i), {2'b0, pin_oe}, {2'b0, VEC[i][29:0]});
    end

    // R7 same-cycle reads of base and alias addresses
    p0_en = 1; p0_addr = 4'd2; p1_en = 1; p1_addr = 4'd8;
    #1;
    check("R7 read OUT_SET", p0_rdata, 32'h2);
    check("R7 read OE_TGL upper zero", p1_rdata, 32'h3FFFFFFF);
    p0_addr = 4'd1; p1_addr = 4'd5;
    #1;
    check("R7 read OUT", p0_rdata, 32'h2);
    check("R7 read OE", p1_rdata, 32'h3FFFFFFF);
    p0_addr = 4'd12;
    #1;
    check("R10 read unmapped", p0_rdata, 0);
    p0_en = 0; p1_addr = 4'd1; p1_en = 0;
    #1;
    check("R10 read disabled", p1_rdata, 0);
    idle();

    // R8 two-flop input path
    @(negedge clk);
    pin_in = 30'h15555555;
    p0_en = 1; p0_addr = 4'd0;
    @(negedge clk);
    check("R8 input after one edge", p0_rdata, 0);
    @(negedge clk);
    check("R8 input after two edges", p0_rdata, 32'h15555555);
    idle();

    // R11 write not visible before the edge
    p0_en = 1; p0_we = 1; p0_addr = 4'd1; p0_wdata = 32'h00ABCDEF;
    #1;
    check("R11 before edge", {2'b0, pin_out}, 32'h2);
    @(negedge clk);
    idle();
    check("R11 after edge", {2'b0, pin_out}, 32'h00ABCDEF);

    // R1 reset mid-run
    rst_n = 0;
    #1;
    check("R1 async reset out", {2'b0, pin_out}, 0);
    check("R1 async reset oe", {2'b0, pin_oe}, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule